// File: doc/BRIEF.md
# Banked GPIO Register Port

This block is a general-purpose I/O controller whose lines can be configured one by one as inputs or outputs through a small 32-bit register bus. The lines are split into banks of eight. Each bank owns two word registers: one holds the value to drive, and one holds the direction bits. The block drives an output-enable and an output value to every pad. It samples every pad input through a two-stage synchronizer.

Register addresses are derived from the bank index, not from a flat table. The map jumps over a 16-byte window at 0x90–0x9F, which is set aside for a separate interrupt-detection block. Software reaches every bank with a single computed address, and the interrupt block can later claim the hole without disturbing any bank. The request side is a valid/ready channel whose ready is always high, so the block never applies back-pressure. A read response is a one-cycle valid pulse with no ready of its own, so the requester must always be able to take it.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: While reset is asserted and afterwards until the first write, every direction bit is 1 (input), every data bit is 0, and pad_oe and pad_out are all zero.
- R2: Bank b has base address A=(b+1)*8, and A is increased by 0x10 when A is 0x90 or more. The data register sits at A+0x0 and the direction register at A+0x4. Line n maps to bank n/8, bit n%8, and there are ceil(LINES/8) banks.
- R3: A direction bit of 0 makes its line an output (pad_oe high). A direction bit of 1 makes it an input (pad_oe low).
- R4: pad_out carries the data register bits, updated on the clock edge that accepts the write. Pad outputs never change in a cycle without an accepted write.
- R5: A data-register read returns, for each output line, the value stored in the data register.
- R6: For an input line, a data-register read returns the pad value after two flops. A read accepted on the first or second edge after a pad change returns the old value. A read accepted on the third edge returns the new value.
- R7: Data bits 31:8 of every read are 0. In the last bank, bit positions at or beyond LINES read as 0 and ignore written ones.
- R8: Any address that hits no register (below 0x08, inside 0x90–0x9F, past the last bank, or not a multiple of 4) reads as 0. A write to such an address changes nothing.
- R9: req_ready is always 1. Each accepted read produces rsp_valid for exactly one cycle, on the edge after the acceptance edge, with rsp_rdata holding the data. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (constant 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data (full word) |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 32 | Read data |
| pad_in | input | LINES | Pad input levels |
| pad_out | output | LINES | Pad output values |
| pad_oe | output | LINES | Pad output enables |

## Verification
The assertions assume that req_valid and req_write never carry X or Z after reset. They also assume that the requester takes every response pulse, since the response channel has no ready signal. The bench keeps within these limits: it drives every request field from a known value and changes inputs only on falling edges. It also changes pad inputs only when a known number of edges separate the change from the reads that observe it. This makes the synchronizer latency visible as exact old and new values.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned BANK_LINES = 8;
  localparam int unsigned HOLE_BASE  = 'h90;
  localparam int unsigned HOLE_SIZE  = 'h10;
  localparam int unsigned OFS_DATA   = 'h0;
  localparam int unsigned OFS_DIR    = 'h4;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2
  } reg_sel_e;

  // bank base: stride of 8 bytes, shifted past the interrupt window
  function automatic int unsigned bank_base(input int unsigned bank);
    int unsigned a;
    a = (bank + 1) * 8;
    if (a >= HOLE_BASE) a = a + HOLE_SIZE;
    return a;
  endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NBANK  = 20,
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned BIDX_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output reg_sel_e          sel,
  output logic [BIDX_W-1:0] bidx
);

  logic [NBANK-1:0] m_data;
  logic [NBANK-1:0] m_dir;

  for (genvar g = 0; g < NBANK; g++) begin : g_cmp
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(bank_base(g) + OFS_DATA);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(bank_base(g) + OFS_DIR);
    assign m_data[g] = (addr == A_DATA);
    assign m_dir[g]  = (addr == A_DIR);
  end

  always_comb begin
    hit  = 1'b0;
    sel  = SEL_NONE;
    bidx = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (m_data[b]) begin
        hit  = 1'b1;
        sel  = SEL_DATA;
        bidx = BIDX_W'(b);
      end
      if (m_dir[b]) begin
        hit  = 1'b1;
        sel  = SEL_DIR;
        bidx = BIDX_W'(b);
      end
    end
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int unsigned NLINE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_data_en,
  input  logic             wr_dir_en,
  input  logic [NLINE-1:0] wdata,
  input  logic [NLINE-1:0] pad_in,
  output logic [NLINE-1:0] pad_out,
  output logic [NLINE-1:0] pad_oe,
  output logic [7:0]       rd_data,
  output logic [7:0]       rd_dir
);

  logic [NLINE-1:0] data_q;
  logic [NLINE-1:0] dir_q;
  logic [NLINE-1:0] sync1_q;
  logic [NLINE-1:0] sync2_q;
  logic [NLINE-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '1;
    end else begin
      if (wr_data_en) data_q <= wdata;
      if (wr_dir_en)  dir_q  <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  assign seen    = (dir_q & sync2_q) | (~dir_q & data_q);
  assign pad_out = data_q;
  assign pad_oe  = ~dir_q;
  assign rd_data = 8'(seen);
  assign rd_dir  = 8'(dir_q);

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned LINES  = 156,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic [LINES-1:0]  pad_in,
  output logic [LINES-1:0]  pad_out,
  output logic [LINES-1:0]  pad_oe
);

  localparam int unsigned NBANK  = (LINES + BANK_LINES - 1) / BANK_LINES;
  localparam int unsigned BIDX_W = (NBANK > 1) ? $clog2(NBANK) : 1;

  logic              dec_hit;
  reg_sel_e          dec_sel;
  logic [BIDX_W-1:0] dec_bidx;
  logic              acc_rd;
  logic              acc_wr;
  logic [7:0]        rd_data_a [NBANK];
  logic [7:0]        rd_dir_a  [NBANK];
  logic [31:0]       rd_word;
  logic              unused_wdata_hi;

  assign req_ready       = 1'b1;
  assign acc_rd          = req_valid & req_ready & ~req_write;
  assign acc_wr          = req_valid & req_ready & req_write;
  assign unused_wdata_hi = ^req_wdata[31:8];

  gpio_addr_dec #(
    .NBANK (NBANK),
    .ADDR_W(ADDR_W),
    .BIDX_W(BIDX_W)
  ) u_dec (
    .addr(req_addr),
    .hit (dec_hit),
    .sel (dec_sel),
    .bidx(dec_bidx)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int unsigned LO = b * BANK_LINES;
    localparam int unsigned NL = ((LINES - LO) >= BANK_LINES) ? BANK_LINES : (LINES - LO);
    logic sel_me;
    assign sel_me = acc_wr & dec_hit & (dec_bidx == BIDX_W'(b));

    gpio_bank #(.NLINE(NL)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_data_en(sel_me & (dec_sel == SEL_DATA)),
      .wr_dir_en (sel_me & (dec_sel == SEL_DIR)),
      .wdata     (req_wdata[NL-1:0]),
      .pad_in    (pad_in[LO +: NL]),
      .pad_out   (pad_out[LO +: NL]),
      .pad_oe    (pad_oe[LO +: NL]),
      .rd_data   (rd_data_a[b]),
      .rd_dir    (rd_dir_a[b])
    );
  end

  always_comb begin
    rd_word = '0;
    if (dec_hit) begin
      if (dec_sel == SEL_DATA) rd_word = {24'd0, rd_data_a[dec_bidx]};
      if (dec_sel == SEL_DIR)  rd_word = {24'd0, rd_dir_a[dec_bidx]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc_rd;
      rsp_rdata <= acc_rd ? rd_word : '0;
    end
  end

endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int unsigned LINES  = 156,
  parameter int unsigned ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic [LINES-1:0]  pad_out,
  input logic [LINES-1:0]  pad_oe
);

  logic in_hole;
  assign in_hole = (req_addr >= ADDR_W'('h90)) && (req_addr < ADDR_W'('hA0));

  p_ready_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready);

  p_rsp_follows_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  p_no_rsp_else_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rdata[31:8] == 24'd0));

  p_pads_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> ($stable(pad_out) && $stable(pad_oe)));

  p_hole_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && in_hole) |=> ($stable(pad_out) && $stable(pad_oe)));

  p_hole_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && in_hole) |=> (rsp_rdata == 32'd0));

endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.LINES(LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_write(req_write),
  .req_addr (req_addr),
  .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe)
);

// File: tb/gpio_bank_ctrl_bench.sv
module gpio_bank_ctrl_bench;

  localparam int LINES  = 156;
  localparam int ADDR_W = 10;
  localparam int NB     = (LINES + 7) / 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic              req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [31:0]       req_wdata;
  logic              rsp_valid;
  logic [31:0]       rsp_rdata;
  logic [LINES-1:0]  pad_in;
  logic [LINES-1:0]  pad_out;
  logic [LINES-1:0]  pad_oe;

  always #5 clk = ~clk;

  gpio_bank_ctrl #(.LINES(LINES), .ADDR_W(ADDR_W)) u_gpio_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  int          checks = 0;
  int          errors = 0;
  bit          done   = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  dat_m [NB];
  logic [7:0]  dir_m [NB];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int base_of(input int b);
    int a;
    a = (b + 1) * 8;
    if (a >= 'h90) a = a + 'h10;
    return a;
  endfunction

  function automatic logic [7:0] lane_mask(input int b);
    logic [7:0] m;
    m = '0;
    for (int i = 0; i < 8; i++) if (8 * b + i < LINES) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [7:0] exp_rd(input int b);
    logic [7:0] v;
    v = '0;
    for (int i = 0; i < 8; i++)
      if (8 * b + i < LINES) v[i] = dir_m[b][i] ? pad_in[8 * b + i] : dat_m[b][i];
    return v;
  endfunction

  function automatic logic [LINES-1:0] model_out(input bit oe);
    logic [LINES-1:0] v;
    for (int n = 0; n < LINES; n++) v[n] = oe ? !dir_m[n / 8][n % 8] : dat_m[n / 8][n % 8];
    return v;
  endfunction

  task automatic do_req(input bit wr, input int addr, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = ADDR_W'(addr);
    req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
  endtask

  task automatic bus_read(input int addr, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    do_req(1'b0, addr, 32'd0);
  endtask

  task automatic wr_data(input int b, input logic [31:0] v);
    dat_m[b] = v[7:0] & lane_mask(b);
    do_req(1'b1, base_of(b), v);
  endtask

  task automatic wr_dir(input int b, input logic [31:0] v);
    dir_m[b] = v[7:0] & lane_mask(b);
    do_req(1'b1, base_of(b) + 4, v);
  endtask

  // monitor: response timing and scoreboard comparison
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      if ((req_valid && !req_write) || rsp_valid)
        check(rsp_valid == (req_valid && req_ready && !req_write),
              "R9 response one cycle after read", 32'(rsp_valid), 32'(req_valid && !req_write));
      if (rsp_valid && exp_q.size() > 0) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_rdata == e, t, rsp_rdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [LINES-1:0] snap_o, snap_e;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    pad_in = '0;
    for (int b = 0; b < NB; b++) begin dat_m[b] = '0; dir_m[b] = lane_mask(b); end
    repeat (3) @(negedge clk);
    check(pad_oe == '0, "R1 reset pad_oe", 32'(pad_oe), 0);
    check(pad_out == '0, "R1 reset pad_out", 32'(pad_out), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset register values, R7 partial last bank
    bus_read(base_of(0) + 4, 32'h0000_00FF, "R1 reset dir bank0");
    bus_read(base_of(NB - 1) + 4, 32'h0000_000F, "R1 R7 reset dir last bank");
    bus_read(base_of(5), 32'h0, "R1 reset data bank5");

    // R3 R4 R5 R6: mixed directions in bank 0
    wr_dir(0, 32'h0F);
    wr_data(0, 32'hA5);
    check(pad_oe[7:0] == 8'hF0, "R3 oe from dir", 32'(pad_oe[7:0]), 32'hF0);
    check(pad_out[7:0] == 8'hA5, "R4 pad_out from data", 32'(pad_out[7:0]), 32'hA5);
    pad_in[7:0] = 8'h3C;
    repeat (3) @(negedge clk);
    bus_read(base_of(0), {24'd0, exp_rd(0)}, "R5 R6 mixed read bank0");

    // R6 synchronizer latency, three back-to-back reads of bank 1
    @(negedge clk);
    exp_q.push_back(32'h00); tag_q.push_back("R6 first edge old");
    exp_q.push_back(32'h00); tag_q.push_back("R6 second edge old");
    exp_q.push_back(32'h5A); tag_q.push_back("R6 third edge new");
    pad_in[15:8] = 8'h5A;
    req_valid = 1'b1; req_write = 1'b0; req_addr = ADDR_W'(base_of(1));
    repeat (3) @(negedge clk);
    req_valid = 1'b0;

    // R2: every bank programmed through its computed address
    for (int b = 0; b < NB; b++) begin
      wr_data(b, 32'(8'h11 * (b % 15 + 1) ^ b));
      wr_dir(b, 32'(b * 7 + 3));
    end
    check(pad_out == model_out(0), "R2 R4 all banks pad_out", 32'(pad_out[LINES-1:LINES-32]), 32'(model_out(0) >> (LINES - 32)));
    check(pad_oe == model_out(1), "R2 R3 all banks pad_oe", 32'(pad_oe[LINES-1:LINES-32]), 32'(model_out(1) >> (LINES - 32)));
    bus_read('h88 + 4, {24'd0, dir_m[16]}, "R2 bank16 dir below hole");
    bus_read('hA0 + 4, {24'd0, dir_m[17]}, "R2 bank17 dir above hole");
    wr_dir(17, 32'h00);
    wr_data(17, 32'h3C);
    check(pad_out[143:136] == 8'h3C, "R2 bank17 at 0xA0", 32'(pad_out[143:136]), 32'h3C);
    check(pad_oe[143:136] == 8'hFF, "R2 R3 bank17 outputs", 32'(pad_oe[143:136]), 32'hFF);
    bus_read('hA0, 32'h3C, "R2 R5 bank17 data");

    // R8 hole and other unmapped addresses
    snap_o = pad_out; snap_e = pad_oe;
    for (int a = 'h90; a < 'hA0; a += 4) do_req(1'b1, a, 32'hFFFF_FFFF);
    do_req(1'b1, 'h00, 32'hFFFF_FFFF);
    do_req(1'b1, 'h0A, 32'hFFFF_FFFF);
    check(pad_out == snap_o, "R8 unmapped writes pad_out", 32'(pad_out[31:0]), 32'(snap_o[31:0]));
    check(pad_oe == snap_e, "R8 unmapped writes pad_oe", 32'(pad_oe[31:0]), 32'(snap_e[31:0]));
    for (int a = 'h90; a < 'hA0; a += 4) bus_read(a, 32'h0, "R8 hole read zero");
    bus_read('h00, 32'h0, "R8 address 0 read zero");
    bus_read('h04, 32'h0, "R8 address 4 read zero");
    bus_read('h0A, 32'h0, "R8 misaligned read zero");
    bus_read('h3FC, 32'h0, "R8 past last bank read zero");

    // R7 last bank partial width
    wr_dir(NB - 1, 32'hFFFF_FF00);
    wr_data(NB - 1, 32'hFFFF_FFFF);
    check(pad_out[155:152] == 4'hF, "R7 last bank pad_out", 32'(pad_out[155:152]), 32'hF);
    check(pad_oe[155:152] == 4'hF, "R7 last bank pad_oe", 32'(pad_oe[155:152]), 32'hF);
    bus_read(base_of(NB - 1), 32'h0000_000F, "R7 last bank data masked");
    bus_read(base_of(NB - 1) + 4, 32'h0, "R7 last bank dir");

    // R9 writes alone give no response (monitor flags any)
    wr_data(3, 32'h77);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9 all read responses seen", 32'(exp_q.size()), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule